// File: doc/BRIEF.md
# Clock source mode controller

This block sits in a clock generator and holds the control registers that pick the system clock source and the active frequency-locked or phase-locked loop. Software writes three control registers over a small register bus. The block drives the select lines of an external clock multiplexer and a loop multiplexer, the enables of both loops, and the FLL reference divide ratio.

The selected source confirms each switch through an acknowledge input. Status fields in a fourth, read-only register follow the request only after a programmable synchronisation delay, and only while the matching acknowledge is high. Software therefore polls the status before it takes the next step of a mode sequence.

A combinational decoder names the current operating mode from the status fields, the low-power bit and the internal-reference bit. In a bypass mode, the low-power bit switches both loops off and leaves the clock selection alone. A loop-select change made while the loops are off only takes effect once the low-power bit is cleared.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, register 0 reads 0x04, registers 1, 2 and 3 read 0x00, `clk_sel_o` is 00 and `mode_o` is 0 (FLL engaged, internal reference).
- R2: Register 0 holds the source request in bits [7:6], the FLL divider code in bits [5:3] and the internal-reference bit in bit 2. `clk_sel_o` follows the source request in the cycle after the write: 00 selects the loop output, 01 the internal reference and 10 the external reference. The value 11 is driven and reported as 10.
- R3: The clock-status field changes to a new request on the SYNC_CYC+2-th rising edge after the write edge, provided the matching acknowledge is high. While that acknowledge is low, the field holds its old value. Once the acknowledge rises, the field updates on the next edge. The acknowledge is `int_ack_i` for 01, `ext_ack_i` for 10, and the acknowledge of the selected loop for 00.
- R4: Register 3 reports the clock status in bits [3:2] and the loop status in bit 5. All its other bits read 0, and writes to it have no effect.
- R5: Register 2 bit 6 is the loop select, with 1 choosing the PLL. `loop_sel_o` follows it. Outside low-power bypass, exactly one of `pll_en_o` and `fll_en_o` is high, matching the loop select. The loop-status bit follows the loop select under the acknowledge rule of R3, using `pll_ack_i` or `fll_ack_i`.
- R6: When register 1 bit 1 (low power) is set and the clock status is 01 or 10, both loop enables are low. The loop-status bit then keeps its value whatever the loop select does, and `clk_sel_o` does not change.
- R7: Clearing the low-power bit with the external source active and the loop select at 0 brings the loop-status bit to 0 and the mode to FBE.
- R8: `mode_o` encodes FEI=0, FEE=1, FBI=2, FBE=3, PEE=4, PBE=5, BLPI=6, BLPE=7.
  - Clock status 00 gives PEE when the loop status is 1. Otherwise it gives FEI when the internal-reference bit is 1 and FEE when it is 0.
  - Clock status 01 gives BLPI when low power is set, and FBI otherwise.
  - Clock status 10 gives BLPE when low power is set. Otherwise it gives PBE when the loop status is 1 and FBE when it is 0.
- R9: `fll_div_o` equals 32 shifted left by the divider code: code 2 gives 128, code 5 gives 1024.
- R10: Unused bits read 0. Register 1 keeps only bit 1. Register 2 keeps bit 6 and bits [4:0], and bits [4:0] drive `pll_div_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and status clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| ext_ack_i | input | 1 | External reference ready for switch |
| int_ack_i | input | 1 | Internal reference ready for switch |
| fll_ack_i | input | 1 | FLL ready for switch |
| pll_ack_i | input | 1 | PLL ready for switch |
| clk_sel_o | output | 2 | Clock multiplexer select |
| loop_sel_o | output | 1 | Loop multiplexer select, 1 = PLL |
| fll_en_o | output | 1 | FLL enable |
| pll_en_o | output | 1 | PLL enable |
| fll_div_o | output | 13 | FLL reference divide ratio |
| pll_div_o | output | 5 | PLL divider field |
| mode_o | output | 3 | Decoded operating mode |

## Verification
The bench builds the block with SYNC_CYC set to 3. This short delay lets the full external-PLL-to-low-power-internal sequence run as a table of writes, each followed by a settle window. It also makes the exact update edge easy to observe: the status still shows the old value one edge before the SYNC_CYC+2-th edge and the new value on it. Because the delay is short, a stall with the acknowledge held low for many times the delay fits in the run, and it shows that the status waits for the acknowledge and not for the counter.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    MODE_FEI  = 3'd0,
    MODE_FEE  = 3'd1,
    MODE_FBI  = 3'd2,
    MODE_FBE  = 3'd3,
    MODE_PEE  = 3'd4,
    MODE_PBE  = 3'd5,
    MODE_BLPI = 3'd6,
    MODE_BLPE = 3'd7
  } mode_e;

  localparam logic [1:0] SRC_LOOP = 2'b00;
  localparam logic [1:0] SRC_INT  = 2'b01;
  localparam logic [1:0] SRC_EXT  = 2'b10;

  localparam logic [1:0] ADDR_SRC  = 2'd0;
  localparam logic [1:0] ADDR_PWR  = 2'd1;
  localparam logic [1:0] ADDR_LOOP = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // reserved request 11 folds onto the external reference
  function automatic logic [1:0] norm_src(input logic [1:0] req);
    return (req == 2'b11) ? SRC_EXT : req;
  endfunction
endpackage

// File: rtl/clk_mode_regs.sv
module clk_mode_regs
  import clk_mode_pkg::*;
#(
  parameter int unsigned DIVC_W = 3,
  parameter int unsigned PDIV_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [1:0]        clk_st_i,
  input  logic              loop_st_i,
  output logic [DW-1:0]     rdata_o,
  output logic [1:0]        src_req_o,
  output logic [DIVC_W-1:0] div_code_o,
  output logic              irefs_o,
  output logic              lp_o,
  output logic              loop_sel_o,
  output logic [PDIV_W-1:0] pll_div_o
);
  logic [1:0]        src_q;
  logic [DIVC_W-1:0] divc_q;
  logic              irefs_q, lp_q, lsel_q;
  logic [PDIV_W-1:0] pdiv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= SRC_LOOP;
      divc_q  <= '0;
      irefs_q <= 1'b1;
      lp_q    <= 1'b0;
      lsel_q  <= 1'b0;
      pdiv_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_SRC: begin
          src_q   <= wdata_i[7:6];
          divc_q  <= wdata_i[5:3];
          irefs_q <= wdata_i[2];
        end
        ADDR_PWR:  lp_q <= wdata_i[1];
        ADDR_LOOP: begin
          lsel_q <= wdata_i[6];
          pdiv_q <= wdata_i[PDIV_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_SRC: rdata_o = {src_q, divc_q, irefs_q, 2'b00};
      ADDR_PWR: rdata_o[1] = lp_q;
      ADDR_LOOP: begin
        rdata_o[6]          = lsel_q;
        rdata_o[PDIV_W-1:0] = pdiv_q;
      end
      default: begin
        rdata_o[3:2] = clk_st_i;
        rdata_o[5]   = loop_st_i;
      end
    endcase
  end

  assign src_req_o  = src_q;
  assign div_code_o = divc_q;
  assign irefs_o    = irefs_q;
  assign lp_o       = lp_q;
  assign loop_sel_o = lsel_q;
  assign pll_div_o  = pdiv_q;
endmodule

// File: rtl/clk_mode_sync.sv
// Status follower: waits SYNC_CYC cycles on a stable request, then needs ack.
module clk_mode_sync #(
  parameter int unsigned W        = 2,
  parameter int unsigned SYNC_CYC = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] tgt_i,
  input  logic         ack_i,
  output logic [W-1:0] stat_o
);
  localparam int unsigned CW = $clog2(SYNC_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(SYNC_CYC);

  logic [W-1:0]  stat_q, last_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= RST_VAL;
      last_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      last_q <= tgt_i;
      if (!en_i || tgt_i == stat_q || tgt_i != last_q) begin
        cnt_q <= '0;
      end else if (cnt_q != CMAX) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (ack_i) begin
        stat_q <= tgt_i;
        cnt_q  <= '0;
      end
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
  import clk_mode_pkg::*;
(
  input  logic [1:0] clk_st_i,
  input  logic       loop_st_i,
  input  logic       lp_i,
  input  logic       irefs_i,
  output mode_e      mode_o
);
  always_comb begin
    unique case (clk_st_i)
      SRC_INT: mode_o = lp_i ? MODE_BLPI : MODE_FBI;
      SRC_EXT: mode_o = lp_i ? MODE_BLPE : (loop_st_i ? MODE_PBE : MODE_FBE);
      default: mode_o = loop_st_i ? MODE_PEE : (irefs_i ? MODE_FEI : MODE_FEE);
    endcase
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int unsigned SYNC_CYC = 4,
  parameter int unsigned DIVC_W   = 3,
  parameter int unsigned PDIV_W   = 5,
  parameter int unsigned BASE_DIV = 32,
  localparam int unsigned FDIV_W  = $clog2(BASE_DIV) + (1 << DIVC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              ext_ack_i,
  input  logic              int_ack_i,
  input  logic              fll_ack_i,
  input  logic              pll_ack_i,
  output logic [1:0]        clk_sel_o,
  output logic              loop_sel_o,
  output logic              fll_en_o,
  output logic              pll_en_o,
  output logic [FDIV_W-1:0] fll_div_o,
  output logic [PDIV_W-1:0] pll_div_o,
  output logic [2:0]        mode_o
);
  logic [1:0]        src_req, clk_tgt, clk_st;
  logic [DIVC_W-1:0] div_code;
  logic              irefs, lp_bit, lsel, loop_st;
  logic              clk_ack, loop_ack, lp_bypass;
  mode_e             mode;

  clk_mode_regs #(.DIVC_W(DIVC_W), .PDIV_W(PDIV_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .clk_st_i  (clk_st),
    .loop_st_i (loop_st),
    .rdata_o   (bus_rdata_o),
    .src_req_o (src_req),
    .div_code_o(div_code),
    .irefs_o   (irefs),
    .lp_o      (lp_bit),
    .loop_sel_o(lsel),
    .pll_div_o (pll_div_o)
  );

  assign clk_tgt   = norm_src(src_req);
  assign lp_bypass = lp_bit && (clk_st != SRC_LOOP);
  assign loop_ack  = lsel ? pll_ack_i : fll_ack_i;

  always_comb begin
    unique case (clk_tgt)
      SRC_INT: clk_ack = int_ack_i;
      SRC_EXT: clk_ack = ext_ack_i;
      default: clk_ack = loop_ack;
    endcase
  end

  clk_mode_sync #(.W(2), .SYNC_CYC(SYNC_CYC), .RST_VAL(SRC_LOOP)) u_clk_sync (
    .clk_i, .rst_ni,
    .en_i  (1'b1),
    .tgt_i (clk_tgt),
    .ack_i (clk_ack),
    .stat_o(clk_st)
  );

  // loop choice only latches while the loops are powered
  clk_mode_sync #(.W(1), .SYNC_CYC(SYNC_CYC), .RST_VAL(1'b0)) u_loop_sync (
    .clk_i, .rst_ni,
    .en_i  (!lp_bypass),
    .tgt_i (lsel),
    .ack_i (loop_ack),
    .stat_o(loop_st)
  );

  clk_mode_decode u_dec (
    .clk_st_i (clk_st),
    .loop_st_i(loop_st),
    .lp_i     (lp_bit),
    .irefs_i  (irefs),
    .mode_o   (mode)
  );

  assign clk_sel_o  = clk_tgt;
  assign loop_sel_o = lsel;
  assign pll_en_o   = !lp_bypass && lsel;
  assign fll_en_o   = !lp_bypass && !lsel;
  assign fll_div_o  = FDIV_W'(BASE_DIV) << div_code;
  assign mode_o     = mode;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] clk_tgt,
  input logic [1:0] clk_st,
  input logic       loop_st,
  input logic       lp_bit,
  input logic       ext_ack_i,
  input logic       int_ack_i,
  input logic       fll_en_o,
  input logic       pll_en_o,
  input logic [1:0] bus_addr_i,
  input logic [7:0] bus_rdata_o,
  input logic [2:0] mode_o
);
  // R3: status only ever moves to the value that was requested
  p_stat_follows_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_st != $past(clk_st)) |-> (clk_st == $past(clk_tgt)));

  // R3: a move to the external source needs its acknowledge
  p_ext_needs_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_st == 2'b10 && $past(clk_st) != 2'b10) |-> $past(ext_ack_i));

  p_int_needs_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_st == 2'b01 && $past(clk_st) != 2'b01) |-> $past(int_ack_i));

  // R5: never both loops on
  p_one_loop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fll_en_o, pll_en_o}));

  // R6: low power in bypass stops loops and freezes loop status
  p_lp_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_bit && clk_st != 2'b00) |-> (!fll_en_o && !pll_en_o));

  p_lp_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lp_bit && clk_st != 2'b00) |-> $stable(loop_st));

  // R8: low-power modes decoded
  p_blpe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_bit && clk_st == 2'b10) |-> (mode_o == 3'd7));

  // R10: unused bits of power register read zero
  p_pwr_unused_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 2'd1) |-> (bus_rdata_o[7:2] == 6'd0 && !bus_rdata_o[0]));
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_tgt    (clk_tgt),
  .clk_st     (clk_st),
  .loop_st    (loop_st),
  .lp_bit     (lp_bit),
  .ext_ack_i  (ext_ack_i),
  .int_ack_i  (int_ack_i),
  .fll_en_o   (fll_en_o),
  .pll_en_o   (pll_en_o),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .mode_o     (mode_o)
);

// File: tb/clk_mode_ctrl_test.sv
module clk_mode_ctrl_test;
  localparam int unsigned SYNC = 3;
  localparam int unsigned NV   = 9;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       bus_we_i = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       ext_ack_i = 1'b1, int_ack_i = 1'b1, fll_ack_i = 1'b1, pll_ack_i = 1'b1;
  logic [1:0] clk_sel_o;
  logic       loop_sel_o, fll_en_o, pll_en_o;
  logic [12:0] fll_div_o;
  logic [4:0] pll_div_o;
  logic [2:0] mode_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  clk_mode_ctrl #(.SYNC_CYC(SYNC)) uut (.*);

  // {addr, data, expected status, expected mode, expected clk_sel, expected {fll_en,pll_en}}
  typedef struct packed {
    logic [1:0] addr;
    logic [7:0] data;
    logic [7:0] stat;
    logic [2:0] mode;
    logic [1:0] sel;
    logic [1:0] en;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd2, 8'h40, 8'h20, 3'd4, 2'b00, 2'b01},  // PEE      R5 R8
    '{2'd0, 8'h90, 8'h28, 3'd5, 2'b10, 2'b01},  // PBE      R2 R8
    '{2'd1, 8'h02, 8'h28, 3'd7, 2'b10, 2'b00},  // BLPE     R6
    '{2'd2, 8'h00, 8'h28, 3'd7, 2'b10, 2'b00},  // loop sel ignored R6
    '{2'd1, 8'h00, 8'h08, 3'd3, 2'b10, 2'b10},  // FBE      R7
    '{2'd0, 8'h54, 8'h04, 3'd2, 2'b01, 2'b10},  // FBI      R8
    '{2'd1, 8'h02, 8'h04, 3'd6, 2'b01, 2'b00},  // BLPI     R6 R8
    '{2'd0, 8'h04, 8'h00, 3'd0, 2'b00, 2'b10},  // FEI, lp no bypass R8
    '{2'd0, 8'h10, 8'h00, 3'd1, 2'b00, 2'b10}   // FEE      R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, d); chk("R1 reg0", d, 8'h04);
    rd(2'd1, d); chk("R1 reg1", d, 8'h00);
    rd(2'd2, d); chk("R1 reg2", d, 8'h00);
    rd(2'd3, d); chk("R1 reg3", d, 8'h00);
    chk("R1 mode", mode_o, 3'd0);
    chk("R1 sel", clk_sel_o, 2'b00);

    // R3 exact update edge
    wr(2'd0, 8'h90);
    chk("R2 sel immediate", clk_sel_o, 2'b10);
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    rd(2'd3, d); chk("R3 before edge", d, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    rd(2'd3, d); chk("R3 on edge", d, 8'h08);
    chk("R9 code2", fll_div_o, 13'd128);

    // back to FEI
    wr(2'd0, 8'h04);
    repeat (SYNC + 3) @(posedge clk_i);
    @(negedge clk_i);
    rd(2'd3, d); chk("R3 back to loop", d, 8'h00);

    // mode walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].addr, VEC[i].data);
      repeat (SYNC + 3) @(posedge clk_i);
      @(negedge clk_i);
      rd(2'd3, d);
      chk($sformatf("R4 R8 vec%0d status", i), d, VEC[i].stat);
      chk($sformatf("R8 vec%0d mode", i), mode_o, VEC[i].mode);
      chk($sformatf("R2 R6 vec%0d sel", i), clk_sel_o, VEC[i].sel);
      chk($sformatf("R5 R6 vec%0d en", i), {fll_en_o, pll_en_o}, VEC[i].en);
    end
    wr(2'd1, 8'h00);

    // R3 ack held low
    ext_ack_i = 1'b0;
    wr(2'd0, 8'hC0);
    chk("R2 reserved 11 as 10", clk_sel_o, 2'b10);
    repeat (4 * SYNC + 10) @(posedge clk_i);
    @(negedge clk_i);
    rd(2'd3, d); chk("R3 hold without ack", d, 8'h00);
    ext_ack_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rd(2'd3, d); chk("R3 update after ack", d, 8'h08);
    chk("R8 FBE", mode_o, 3'd3);

    // R9 divider
    wr(2'd0, 8'h2C);
    chk("R9 code5", fll_div_o, 13'd1024);

    // R10 / R4 unused bits and read-only status
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R10 reg1", d, 8'h02);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hBF);
    rd(2'd2, d); chk("R10 reg2", d, 8'h1F);
    chk("R10 pll_div", pll_div_o, 5'h1F);
    chk("R5 loop_sel", loop_sel_o, 1'b0);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R4 status write ignored", d[7:6] | {d[4], d[1:0]}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule